// File: doc/BRIEF.md
# Distributed Shared-Bus Arbitration Node

Each processor on a shared external bus carries one copy of this arbitration node. The six nodes have no central arbiter. A node drives only the request line that matches its hardware ID, and it samples all six lines every cycle. Every node runs the same state machine on those same samples, so every node reaches the same conclusion about which processor owns the bus. Mastership moves only when the owner lets go of its line.

The owner keeps the bus for as long as its line stays high. If the owner drops its line while no other line is high, the bus is parked with that owner and no cycle is lost. If the owner drops its line while one or more other lines are high, the node registers a winner and spends exactly one handover cycle with no owner. The winner takes the bus on the next cycle.

A mode input chooses the priority scheme:
- **Fixed:** the lowest index wins.
- **Rotating:** the search starts at the node after the one that is giving up the bus, so the outgoing owner has the lowest priority.

A hold limit can force the owner to release the bus after a set number of cycles. A lock input overrides that limit so that a read-modify-write sequence is not split.

The state machine has three states:
- **ST_HELD:** the owner's line is high.
- **ST_PARKED:** the owner's line is low and no one else is requesting.
- **ST_HANDOVER:** the one-cycle gap between owners.

It has five transitions:
- **keep:** from ST_HELD or ST_PARKED to ST_HELD, when the owner's line is high.
- **park:** from ST_HELD or ST_PARKED to ST_PARKED, when all lines are low.
- **release:** from ST_HELD or ST_PARKED to ST_HANDOVER, when the owner's line is low and another line is high.
- **install:** from ST_HANDOVER to ST_HELD, always.
- **reset:** to ST_HELD with node index 0 as owner.

Top module: `busarb_node`

## Requirements
- R1: After reset, every node reports owner index 0 (ID1) and state ST_HELD. The node with index 0 raises is_master, and handover is low.
- R2: A node that is not the owner drives req_out equal to want_bus. The owner does the same unless it is force-released by the hold limit (R8).
- R3: While the owner's request line is sampled high, the owner stays the same and no handover starts, whatever the other lines do.
- R4: If the owner's line is sampled low and every other line is low, the state becomes ST_PARKED. The owner keeps the bus and keeps is_master, with no handover cycle.
- R5: If the owner's line is sampled low and some other line is high, the next cycle is a handover cycle. In that cycle handover is 1, no node has is_master, and master_id still shows the old owner. The cycle after it, the winner is owner with is_master set.
- R6: With rotate_en low, the winner is the lowest-indexed line that is high in the sampled cycle. Index 0 has the highest priority.
- R7: With rotate_en high, the winner is the first high line found by searching upward from old owner index + 1, wrapping modulo 6. The outgoing owner is therefore the lowest priority.
- R8: An owning cycle counter starts at 0 when a node becomes owner. It grows by one for each cycle the owner's line is sampled high, saturating at 15, and is cleared when the line is low. When hold_limit is non-zero, the count is at least hold_limit and bus_lock is low, the owner's req_out is forced low. A hold_limit of 0 disables this.
- R9: While bus_lock is high, the owner's req_out equals want_bus even after its hold limit has expired.
- R10: In every cycle all nodes report the same master_id, and at most one node has is_master.
- R11: handover rises only after a sampled cycle in which the owner's line was low and another line was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | 3 | Hardware index of this node, 0 to 5 |
| rotate_en | input | 1 | 1 selects rotating priority; 0 selects fixed priority |
| want_bus | input | 1 | The local processor wants the bus |
| bus_lock | input | 1 | Keeps the bus through an indivisible sequence; overrides the hold limit |
| hold_limit | input | 4 | Number of owning cycles before forced release; 0 disables the limit |
| req_in | input | 6 | All six shared request lines as sampled |
| req_out | output | 1 | This node's request line |
| is_master | output | 1 | This node owns the bus in this cycle |
| master_id | output | 3 | Index of the current or outgoing owner |
| handover | output | 1 | This cycle is the one-cycle owner changeover |

## Verification
Two functions can act in the same cycle: expiry of the hold limit and the lock input. The bench provokes this by holding hold_limit at 1 to 3 and toggling bus_lock pseudo-randomly, so that lock often falls exactly when the counter has passed the limit. A second collision is the owner's release arriving together with several new requests in rotating mode; the fixed-versus-rotating sweeps provoke it. A cycle-accurate arithmetic model in the bench judges every line, owner index, is_master flag and handover flag on all six instances in every cycle.

// File: rtl/busarb_pkg.sv
package busarb_pkg;
    typedef enum logic [1:0] {
        ST_HELD     = 2'd0,
        ST_PARKED   = 2'd1,
        ST_HANDOVER = 2'd2
    } arb_state_e;
endpackage

// File: rtl/busarb_pick.sv
// Priority search over the sampled request lines.
module busarb_pick #(
    parameter int N   = 6,
    parameter int IDW = 3
) (
    input  logic [N-1:0]   req,
    input  logic           rotate_en,
    input  logic [IDW-1:0] last_owner,
    output logic [IDW-1:0] winner,
    output logic           found
);
    always_comb begin
        int base;
        base   = rotate_en ? (int'(last_owner) + 1) : 0;
        if (base >= N) base = base - N;
        winner = '0;
        found  = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = base + k;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                found  = 1'b1;
                winner = IDW'(idx);
            end
        end
    end

    // The chosen winner must be an active line (R6/R7)
    always_comb begin
        if (found) begin
            p_win_active_r6: assert (req[winner]);
        end
    end
endmodule

// File: rtl/busarb_track.sv
// Ownership tracking state machine; identical in every node.
module busarb_track
    import busarb_pkg::*;
#(
    parameter int N   = 6,
    parameter int CW  = 4,
    parameter int IDW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   req_in,
    input  logic           rotate_en,
    output arb_state_e     state,
    output logic [IDW-1:0] owner,
    output logic [CW-1:0]  own_cnt
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    arb_state_e     state_n;
    logic [IDW-1:0] owner_n, win_q, win_n, pick_w;
    logic [CW-1:0]  cnt_n;
    logic [N-1:0]   owner_mask, others;
    logic           owner_line, pick_ok;

    assign owner_mask = {{(N-1){1'b0}}, 1'b1} << owner;
    assign others     = req_in & ~owner_mask;
    assign owner_line = |(req_in & owner_mask);

    busarb_pick #(.N(N), .IDW(IDW)) u_pick (
        .req        (others),
        .rotate_en  (rotate_en),
        .last_owner (owner),
        .winner     (pick_w),
        .found      (pick_ok)
    );

    always_comb begin
        state_n = state;
        owner_n = owner;
        win_n   = win_q;
        cnt_n   = '0;
        unique case (state)
            ST_HANDOVER: begin            // install
                state_n = ST_HELD;
                owner_n = win_q;
            end
            ST_HELD, ST_PARKED: begin
                if (owner_line) begin     // keep
                    state_n = ST_HELD;
                    cnt_n   = (own_cnt == CNT_MAX) ? own_cnt : own_cnt + 1'b1;
                end else if (pick_ok) begin // release
                    state_n = ST_HANDOVER;
                    win_n   = pick_w;
                end else begin            // park
                    state_n = ST_PARKED;
                end
            end
            default: state_n = ST_HELD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_HELD;
            owner   <= '0;
            win_q   <= '0;
            own_cnt <= '0;
        end else begin
            state   <= state_n;
            owner   <= owner_n;
            win_q   <= win_n;
            own_cnt <= cnt_n;
        end
    end

    p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_HANDOVER && owner_line) |=> (state == ST_HELD && $stable(owner)));
    p_park_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_HANDOVER && req_in == '0) |=> (state == ST_PARKED && $stable(owner)));
    p_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_HANDOVER && !owner_line && others != '0) |=> (state == ST_HANDOVER && $stable(owner)));
    p_install_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HANDOVER) |=> (state == ST_HELD));
    p_only_on_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_HANDOVER && !(!owner_line && others != '0)) |=> (state != ST_HANDOVER));
    p_owner_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(owner) < N);
endmodule

// File: rtl/busarb_node.sv
// One arbitration node; six copies share the request lines.
module busarb_node
    import busarb_pkg::*;
#(
    parameter  int N   = 6,
    parameter  int CW  = 4,
    localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [IDW-1:0] node_id,
    input  logic           rotate_en,
    input  logic           want_bus,
    input  logic           bus_lock,
    input  logic [CW-1:0]  hold_limit,
    input  logic [N-1:0]   req_in,
    output logic           req_out,
    output logic           is_master,
    output logic [IDW-1:0] master_id,
    output logic           handover
);
    arb_state_e     state;
    logic [IDW-1:0] owner;
    logic [CW-1:0]  own_cnt;
    logic           mine, limit_hit;

    busarb_track #(.N(N), .CW(CW), .IDW(IDW)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_in    (req_in),
        .rotate_en (rotate_en),
        .state     (state),
        .owner     (owner),
        .own_cnt   (own_cnt)
    );

    assign mine      = (owner == node_id);
    assign limit_hit = (state != ST_HANDOVER) && (hold_limit != '0)
                       && (own_cnt >= hold_limit) && !bus_lock;

    always_comb begin
        req_out   = want_bus && !(mine && limit_hit);
        is_master = mine && (state != ST_HANDOVER);
        handover  = (state == ST_HANDOVER);
        master_id = owner;
    end

    p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !is_master |-> (req_out == want_bus));
    p_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && bus_lock) |-> (req_out == want_bus));
    p_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !bus_lock && hold_limit != '0 && req_out) |-> (own_cnt < hold_limit));
    p_no_owner_in_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        handover |-> !is_master);
endmodule

// File: tb/busarb_node_bench.sv
`timescale 1ns/1ps
module busarb_node_bench;
    localparam int N    = 6;
    localparam int CW   = 4;
    localparam int CMAX = 15;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rot;
    logic [N-1:0]  want, lockv;
    logic [CW-1:0] lim;
    wire  [N-1:0]  req_bus;
    logic [N-1:0]  ism, hov;
    logic [2:0]    mid [N];

    int checks = 0, errors = 0;
    int mM, ms, mWin, mCnt;   // ms: 0 held, 1 parked, 2 handover
    bit mChanged, mRotAtPick;
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    for (genvar i = 0; i < N; i++) begin : g_node
        busarb_node #(.N(N), .CW(CW)) u_busarb_node (
            .clk(clk), .rst_n(rst_n), .node_id(3'(i)), .rotate_en(rot),
            .want_bus(want[i]), .bus_lock(lockv[i]), .hold_limit(lim),
            .req_in(req_bus), .req_out(req_bus[i]), .is_master(ism[i]),
            .master_id(mid[i]), .handover(hov[i])
        );
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int pick(logic [N-1:0] r, bit rt, int last);
        int base = rt ? (last + 1) % N : 0;
        for (int k = 0; k < N; k++)
            if (r[(base + k) % N]) return (base + k) % N;
        return 0;
    endfunction

    function automatic logic [15:0] step_lfsr(logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    // Called at a falling edge with inputs driven; ends at the next falling edge.
    task automatic cycle();
        logic [N-1:0] er;
        string sit;
        int others;
        #1;
        for (int i = 0; i < N; i++) begin
            bool_expire: begin end
            er[i] = want[i] && !(i == mM && ms != 2 && lim != 0 && mCnt >= int'(lim) && !lockv[i]);
        end
        if (ms == 2)        sit = "R5";
        else if (mChanged)  sit = mRotAtPick ? "R7" : "R6";
        else if (ms == 1)   sit = "R4";
        else                sit = "R3";
        for (int i = 0; i < N; i++) begin
            bit lim_case = (i == mM && ms != 2 && lim != 0 && mCnt >= int'(lim));
            chk(req_bus[i] == er[i], lim_case ? (lockv[i] ? "R9" : "R8") : "R2",
                int'(req_bus[i]), int'(er[i]));
            chk(int'(mid[i]) == mM, sit, int'(mid[i]), mM);
            chk(ism[i] == (ms != 2 && i == mM), sit, int'(ism[i]), int'(ms != 2 && i == mM));
            chk(hov[i] == (ms == 2), "R11", int'(hov[i]), int'(ms == 2));
            chk(mid[i] == mid[0], "R10", int'(mid[i]), int'(mid[0]));
        end
        chk($countones(ism) <= 1, "R10", $countones(ism), 1);
        // model next state
        mChanged = 1'b0;
        others = 0;
        for (int i = 0; i < N; i++) if (i != mM && er[i]) others = 1;
        @(posedge clk);
        if (ms == 2) begin
            mM = mWin; ms = 0; mCnt = 0; mChanged = 1'b1;
        end else if (er[mM]) begin
            ms = 0; mCnt = (mCnt == CMAX) ? CMAX : mCnt + 1;
        end else if (others != 0) begin
            logic [N-1:0] o = er;
            o[mM] = 1'b0;
            ms = 2; mCnt = 0; mWin = pick(o, rot, mM); mRotAtPick = rot;
        end else begin
            ms = 1; mCnt = 0;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rot = 1'b0; want = '0; lockv = '0; lim = '0;
        mM = 0; ms = 0; mWin = 0; mCnt = 0; mChanged = 1'b0; mRotAtPick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int i = 0; i < N; i++) begin
            chk(mid[i] == 3'd0, "R1", int'(mid[i]), 0);
            chk(ism[i] == (i == 0), "R1", int'(ism[i]), int'(i == 0));
            chk(hov[i] == 1'b0, "R1", int'(hov[i]), 0);
        end
        @(negedge clk);
        // Directed: park with no requests (R4), then release to node 3 (R5)
        repeat (3) cycle();
        want = 6'b001000; repeat (4) cycle();
        want = 6'b101001; repeat (3) cycle();
        // Sweep of every request pattern in both priority modes, no limit
        for (int r = 0; r < 2; r++) begin
            rot = r[0];
            for (int p = 0; p < 64; p++) begin
                want = 6'(p);
                repeat (3) cycle();
            end
        end
        // Limit sweep with lock toggling
        for (int r = 0; r < 2; r++) begin
            rot = r[0];
            for (int L = 1; L <= 3; L++) begin
                lim = 4'(L);
                for (int p = 0; p < 64; p++) begin
                    lfsr = step_lfsr(lfsr);
                    want  = 6'(p) | 6'(lfsr[5:0] & 6'b100001);
                    lockv = lfsr[7] ? 6'b111111 : 6'b000000;
                    repeat (2) cycle();
                end
            end
        end
        // Pseudo-random run
        for (int n = 0; n < 3000; n++) begin
            lfsr  = step_lfsr(lfsr);
            want  = lfsr[5:0] | lfsr[11:6];
            lockv = (lfsr[14:12] == 3'd0) ? 6'b111111 : 6'b000000;
            if (lfsr[15:13] == 3'd7) rot = ~rot;
            if (lfsr[9:7] == 3'd5) lim = 4'(lfsr[2:0] % 5);
            cycle();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule